// File: doc/BRIEF.md
# Program Memory Lock Controller

This block turns three one-time lock fuses into access permissions for an on-chip program memory. It decodes the fuses into one of four cumulative protection levels and answers the requests around the memory: code fetches, table reads issued by running code, programming, verify reads and signature reads. It also decides whether each fetch is routed to internal or external memory, based on the external-access pin. From protection level 2 upward, it uses a copy of that pin captured during reset rather than the live pin.

The memory array sits outside the block. Its read byte comes in on `mem_rdata` and passes through to the table-read and verify outputs only when access is allowed. Otherwise those outputs show 0xFF. A lock-write check refuses any write that would return a fuse to the unprogrammed state. All permission outputs are combinational. The only register is the captured external-access level.

Top module: `prog_lock_ctrl`

## Requirements
- R1: `lock_bits[0]`, `[1]` and `[2]` are fuses 1, 2 and 3, and 1 means programmed. The highest programmed fuse sets the level: fuse 3 gives level 4, else fuse 2 gives level 3, else fuse 1 gives level 2, else level 1. `prot_level` reports the level minus one.
- R2: `prog_ok` is high only when `prog_req` is high and the level is 1.
- R3: A table read with `tbl_from_ext` high whose address falls in internal memory (`ea_eff` high and address below 0x2000) is refused at level 2 and above. A refused read has `tbl_ok` low and `tbl_data` = 0xFF. A granted read outputs `mem_rdata`.
- R4: A verify read (`ver_req` high, `sig_sel` low) is refused at levels 3 and 4, with `ver_data` = 0xFF. At levels 1 and 2 it outputs `mem_rdata`.
- R5: With `ver_req` and `sig_sel` high, `ver_data` returns 0x37, 0x6E and 0x7F for addresses 0x30, 0x31 and 0x32, and 0xFF for any other address. This holds at every level.
- R6: `fetch_ext` is high when `ea_eff` is low, or when `fetch_addr` is 0x2000 or above.
- R7: At level 4, a fetch routed to external memory has `fetch_ok` low. Internal fetches are still granted.
- R8: At levels 2 to 4, `ea_eff` equals the value `ea_pin` had at the last clock edge while `rst` was high. At level 1, `ea_eff` follows `ea_pin` directly.
- R9: `lock_wr_ok` is high when `lock_wr_req` is high and `lock_wr_val` keeps every fuse that is already programmed. It is low otherwise.
- R10: With no request active, every `*_ok` output is low and both data outputs read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; the external-access pin is captured while it is high |
| lock_bits | input | 3 | Fuse state, 1 = programmed |
| ea_pin | input | 1 | External-access pin (low = execute from external memory) |
| lock_wr_req | input | 1 | Lock-write request |
| lock_wr_val | input | 3 | Requested new fuse state |
| lock_wr_ok | output | 1 | Lock write allowed |
| fetch_req | input | 1 | Code fetch request |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_ext | output | 1 | Fetch is routed to external memory |
| fetch_ok | output | 1 | Fetch granted |
| tbl_req | input | 1 | Table-read request |
| tbl_from_ext | input | 1 | Table read issued by code running from external memory |
| tbl_addr | input | ADDR_W | Table-read address |
| tbl_ok | output | 1 | Table read granted |
| tbl_data | output | DATA_W | Table-read data, 0xFF when refused |
| prog_req | input | 1 | Programming request |
| prog_ok | output | 1 | Programming granted |
| ver_req | input | 1 | Verify or signature read request |
| sig_sel | input | 1 | Selects a signature read instead of a verify |
| ver_addr | input | ADDR_W | Verify/signature address |
| ver_ok | output | 1 | Verify or signature read granted |
| ver_data | output | DATA_W | Verify/signature data |
| mem_rdata | input | DATA_W | Byte read from the memory array |
| ea_eff | output | 1 | Effective external-access level |
| prot_level | output | 2 | Protection level minus one |

## Verification
The bench uses the default widths: a 16-bit address, an 8-bit data path and 13 internal address bits. With these, the internal/external boundary sits at 0x1FFF/0x2000, and the bench probes both sides of it for fetches and table reads. The bench walks all eight fuse combinations, so the combinations outside the four defined levels are covered as well as the defined ones. It also resets the block with the pin high and then drops the pin, so that the captured and live external-access behaviour can be told apart.

// File: rtl/prog_lock_ctrl.sv
module prog_lock_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int INT_AW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        lock_bits,
  input  logic              ea_pin,
  input  logic              lock_wr_req,
  input  logic [2:0]        lock_wr_val,
  output logic              lock_wr_ok,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ext,
  output logic              fetch_ok,
  input  logic              tbl_req,
  input  logic              tbl_from_ext,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic              tbl_ok,
  output logic [DATA_W-1:0] tbl_data,
  input  logic              prog_req,
  output logic              prog_ok,
  input  logic              ver_req,
  input  logic              sig_sel,
  input  logic [ADDR_W-1:0] ver_addr,
  output logic              ver_ok,
  output logic [DATA_W-1:0] ver_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ea_eff,
  output logic [1:0]        prot_level
);
  localparam logic [DATA_W-1:0] BLANK = '1;

  logic [1:0]        lvl;
  logic              ea_hold;
  logic              tbl_internal;
  logic [DATA_W-1:0] sig_byte;

  always_comb begin
    if (lock_bits[2])      lvl = 2'd3;
    else if (lock_bits[1]) lvl = 2'd2;
    else if (lock_bits[0]) lvl = 2'd1;
    else                   lvl = 2'd0;
  end

  always_ff @(posedge clk)
    if (rst) ea_hold <= ea_pin;

  assign prot_level = lvl;
  assign ea_eff     = (lvl != 2'd0) ? ea_hold : ea_pin;

  assign fetch_ext = !ea_eff || (|fetch_addr[ADDR_W-1:INT_AW]);
  assign fetch_ok  = fetch_req && !(lvl == 2'd3 && fetch_ext);

  assign tbl_internal = ea_eff && !(|tbl_addr[ADDR_W-1:INT_AW]);
  assign tbl_ok   = tbl_req && !(lvl != 2'd0 && tbl_from_ext && tbl_internal);
  assign tbl_data = tbl_ok ? mem_rdata : BLANK;

  assign prog_ok = prog_req && (lvl == 2'd0);

  always_comb begin
    sig_byte = BLANK;
    if (ver_addr == ADDR_W'(8'h30))      sig_byte = DATA_W'(8'h37);
    else if (ver_addr == ADDR_W'(8'h31)) sig_byte = DATA_W'(8'h6E);
    else if (ver_addr == ADDR_W'(8'h32)) sig_byte = DATA_W'(8'h7F);
  end

  assign ver_ok   = ver_req && (sig_sel || !lvl[1]);
  assign ver_data = !ver_ok ? BLANK : (sig_sel ? sig_byte : mem_rdata);

  assign lock_wr_ok = lock_wr_req && ((lock_wr_val & lock_bits) == lock_bits);

  p_prog_locked_r2: assert property (@(posedge clk) disable iff (rst)
    prog_ok |-> (lock_bits == 3'b000));

  p_tbl_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (tbl_req && !tbl_ok) |-> (tbl_data == BLANK));

  p_verify_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (ver_req && !sig_sel && lock_bits[2:1] != 2'b00) |-> (ver_data == BLANK));

  p_no_ext_exec_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_ok && lock_bits[2]) |-> !fetch_ext);

  p_ea_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lvl != 2'd0 && $past(lvl) != 2'd0) |-> (ea_eff == $past(ea_eff)));

  p_lock_monotonic_r9: assert property (@(posedge clk) disable iff (rst)
    lock_wr_ok |-> ((lock_wr_val | lock_bits) == lock_wr_val));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!fetch_req && !tbl_req && !prog_req && !ver_req && !lock_wr_req)
      |-> (!fetch_ok && !tbl_ok && !prog_ok && !ver_ok && !lock_wr_ok));
endmodule

// File: tb/prog_lock_ctrl_test.sv
module prog_lock_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  lock_bits = '0;
  logic        ea_pin = 1;
  logic        lock_wr_req = 0;
  logic [2:0]  lock_wr_val = '0;
  logic        lock_wr_ok;
  logic        fetch_req = 0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ext, fetch_ok;
  logic        tbl_req = 0, tbl_from_ext = 0;
  logic [15:0] tbl_addr = '0;
  logic        tbl_ok;
  logic [7:0]  tbl_data;
  logic        prog_req = 0, prog_ok;
  logic        ver_req = 0, sig_sel = 0;
  logic [15:0] ver_addr = '0;
  logic        ver_ok;
  logic [7:0]  ver_data;
  logic [7:0]  mem_rdata = 8'hA5;
  logic        ea_eff;
  logic [1:0]  prot_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_lock_ctrl uut (
    .clk, .rst, .lock_bits, .ea_pin, .lock_wr_req, .lock_wr_val, .lock_wr_ok,
    .fetch_req, .fetch_addr, .fetch_ext, .fetch_ok,
    .tbl_req, .tbl_from_ext, .tbl_addr, .tbl_ok, .tbl_data,
    .prog_req, .prog_ok, .ver_req, .sig_sel, .ver_addr, .ver_ok, .ver_data,
    .mem_rdata, .ea_eff, .prot_level
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk);
    ea_pin = pin;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_idle();
    settle();
    check("R10 ok idle", {fetch_ok, tbl_ok, prog_ok, ver_ok, lock_wr_ok}, 0);
    check("R10 tbl_data idle", tbl_data, 16'hFF);
    check("R10 ver_data idle", ver_data, 16'hFF);
  endtask

  task automatic t_levels();
    for (int b = 0; b < 8; b++) begin
      lock_bits = 3'(b);
      settle();
      check("R1 level", prot_level, b[2] ? 3 : b[1] ? 2 : b[0] ? 1 : 0);
    end
  endtask

  task automatic t_prog();
    prog_req = 1;
    for (int b = 0; b < 8; b++) begin
      lock_bits = 3'(b);
      settle();
      check("R2 prog_ok", prog_ok, b == 0);
    end
    prog_req = 0;
  endtask

  task automatic t_table();
    tbl_req = 1;
    mem_rdata = 8'h5C;
    for (int b = 0; b < 8; b++) begin
      lock_bits = 3'(b);
      tbl_from_ext = 1; tbl_addr = 16'h1FFF;
      settle();
      check("R3 tbl internal from ext", tbl_data, b == 0 ? 16'h5C : 16'hFF);
      tbl_addr = 16'h2000;
      settle();
      check("R3 tbl external addr", tbl_data, 16'h5C);
      tbl_from_ext = 0; tbl_addr = 16'h0100;
      settle();
      check("R3 tbl from internal", tbl_ok, 1);
    end
    tbl_req = 0;
  endtask

  task automatic t_verify();
    ver_req = 1; sig_sel = 0; ver_addr = 16'h0040;
    mem_rdata = 8'h3C;
    for (int b = 0; b < 8; b++) begin
      lock_bits = 3'(b);
      settle();
      check("R4 verify data", ver_data, (b >= 2) ? 16'hFF : 16'h3C);
    end
    ver_req = 0;
  endtask

  task automatic t_sig();
    ver_req = 1; sig_sel = 1;
    for (int b = 0; b < 8; b += 7) begin
      lock_bits = 3'(b);
      ver_addr = 16'h0030; settle(); check("R5 sig 30", ver_data, 16'h37);
      ver_addr = 16'h0031; settle(); check("R5 sig 31", ver_data, 16'h6E);
      ver_addr = 16'h0032; settle(); check("R5 sig 32", ver_data, 16'h7F);
      ver_addr = 16'h0033; settle(); check("R5 sig other", ver_data, 16'hFF);
    end
    ver_req = 0; sig_sel = 0;
  endtask

  task automatic t_fetch();
    lock_bits = 3'b000;
    fetch_req = 1;
    ea_pin = 1;
    fetch_addr = 16'h1FFF; settle(); check("R6 ext high internal", fetch_ext, 0);
    fetch_addr = 16'h2000; settle(); check("R6 ext high above", fetch_ext, 1);
    ea_pin = 0;
    fetch_addr = 16'h0000; settle(); check("R6 ext low", fetch_ext, 1);
    check("R7 level1 ext fetch ok", fetch_ok, 1);
    fetch_req = 0;
  endtask

  task automatic t_level4();
    lock_bits = 3'b111;
    do_reset(1);
    fetch_req = 1;
    fetch_addr = 16'h0010; settle(); check("R7 l4 internal fetch", fetch_ok, 1);
    fetch_addr = 16'hF000; settle(); check("R7 l4 external fetch", fetch_ok, 0);
    fetch_req = 0;
  endtask

  task automatic t_ea_latch();
    lock_bits = 3'b001;
    do_reset(1);
    ea_pin = 0;
    settle(); check("R8 latched high", ea_eff, 1);
    fetch_req = 1; fetch_addr = 16'h0100;
    settle(); check("R8 latched routing", fetch_ext, 0);
    fetch_req = 0;
    do_reset(0);
    ea_pin = 1;
    settle(); check("R8 latched low", ea_eff, 0);
    lock_bits = 3'b000;
    settle(); check("R8 live level1", ea_eff, 1);
    ea_pin = 0;
    settle(); check("R8 live follows", ea_eff, 0);
  endtask

  task automatic t_lock_wr();
    lock_wr_req = 1;
    lock_bits = 3'b011;
    lock_wr_val = 3'b111; settle(); check("R9 add bit", lock_wr_ok, 1);
    lock_wr_val = 3'b011; settle(); check("R9 same", lock_wr_ok, 1);
    lock_wr_val = 3'b101; settle(); check("R9 clears bit", lock_wr_ok, 0);
    lock_wr_val = 3'b000; settle(); check("R9 clears all", lock_wr_ok, 0);
    lock_wr_req = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1);
    t_idle();
    t_levels();
    t_prog();
    t_table();
    t_verify();
    t_sig();
    t_fetch();
    t_level4();
    t_ea_latch();
    t_lock_wr();
    lock_bits = 3'b000;
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule